// File: doc/BRIEF.md
# Serial Absolute-Maximum Pooling Unit

This block reduces one local pooling window to one value: the largest magnitude among the window's signed samples. Samples arrive one at a time with markers for the first and the last element of the window. Each sample is turned into its magnitude. The magnitude is then compared against a running maximum by a single comparator. After the last element has been handled, the unit presents the window result for one cycle.

The comparator is modelled as a stage whose decision takes a variable number of cycles. That latency is supplied with each sample. A programmable deadline bounds the wait. If the decision is not ready by the deadline, the unit does not stall. It takes an arbitrary outcome, keeps the current maximum, and marks the window as having timed out. While a compare is in progress, the unit holds off new samples with `in_ready`. When no valid sample is offered, no compare takes place and the state does not change.

Top module: `win_absmax_pool`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, `out_max` is 0 and `out_timeout` is 0.
- R2: Negative samples take part by magnitude. For example, a window holding 5, -20 and 7 yields 20.
- R3: The most negative code (0x80 for 8-bit data) is treated as magnitude 127, the largest positive code.
- R4: A sample marked first loads its magnitude as the new maximum without a compare. `in_ready` stays 1 on the cycle after it is accepted, whatever latency is supplied.
- R5: A compare that resolves in time leaves the maximum equal to the larger of the previous maximum and the new magnitude.
- R6: `out_valid` is 1 for exactly one cycle, starting on the cycle after the last sample's handling completes. For a one-sample window, that is the cycle right after the sample is accepted.
- R7: After a sample not marked first is accepted, `in_ready` is 0 for min(max(L,1), D) cycles, where L is `in_lat` and D is the deadline. A decision that becomes ready on the deadline cycle counts as resolved.
- R8: If L is greater than D, the decision is forced when D cycles have elapsed, and the current maximum is kept.
- R9: `out_timeout` goes with the result and is 1 if any compare in that window was forced. The flag is cleared by the next sample marked first.
- R10: A deadline input of 0 is treated as 1.
- R11: Inputs on cycles where `in_valid` is 0, including a first marker or the most negative code, leave the result of the ongoing window unchanged and start no compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A sample is offered |
| in_first | input | 1 | Sample is the first of its window |
| in_last | input | 1 | Sample is the last of its window |
| in_data | input | DATA_W | Signed two's-complement sample |
| in_lat | input | CNT_W | Cycles the comparator needs to decide for this sample |
| in_deadline | input | CNT_W | Decision deadline in cycles (1 to 15; 0 acts as 1) |
| in_ready | output | 1 | Sample accepted when both this and in_valid are 1 |
| out_valid | output | 1 | One-cycle pulse marking a window result |
| out_max | output | DATA_W-1 | Largest magnitude of the window |
| out_timeout | output | 1 | Some compare in the window was forced |

## Verification
A corrupted running maximum stays hidden until the window closes. It then shows as a wrong `out_max` on the single `out_valid` cycle, which is at most one deadline after the last sample is accepted. A compare counter that runs too long or too short shows earlier. The number of cycles `in_ready` spends low after each non-first sample then differs from min(max(L,1), D). A stuck or leaked timeout flag appears in `out_timeout` on the result of the window in which it arose, or on the clean window that follows.

// File: rtl/win_pool_pkg.sv
// Shared types for the serial absolute-maximum pooling unit.
// Assumes nothing beyond IEEE 1800-2017 packages.
package win_pool_pkg;

    // Default geometry of the unit.
    localparam int DEF_DATA_W = 8;
    localparam int DEF_CNT_W  = 4;

    // Outcome of the comparator stage in a given cycle.
    typedef enum logic [1:0] {
        DEC_NONE     = 2'd0,
        DEC_RESOLVED = 2'd1,
        DEC_FORCED   = 2'd2
    } dec_e;

endpackage

// File: rtl/wp_abs_sat.sv
// Saturating magnitude of a signed sample.
// Output is one bit narrower than the input; the most negative code,
// whose true magnitude does not fit, maps to the largest positive code.
module wp_abs_sat #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    output logic [W-2:0] mag
);

    localparam logic [W-2:0] MAG_MAX = '1;

    logic [W-1:0] neg_v;
    logic         most_neg;

    // Form the two's-complement negation and detect the unrepresentable code.
    always_comb begin
        neg_v    = ~din + 1'b1;
        most_neg = din[W-1] && (din[W-2:0] == '0);
    end

    // Select the magnitude with saturation.
    always_comb begin
        if (most_neg)
            mag = MAG_MAX;
        else if (din[W-1])
            mag = neg_v[W-2:0];
        else
            mag = din[W-2:0];
    end

endmodule

// File: rtl/wp_cmp_timer.sv
// Comparator decision timer.
// Counts compare cycles from a start pulse. It reports a resolved decision
// once the sampled latency has elapsed, or a forced decision once the
// sampled deadline is reached first. Assumes start is only raised while idle.
module wp_cmp_timer
    import win_pool_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] lat_in,
    input  logic [CW-1:0] dl_in,
    output logic          busy,
    output dec_e          dec
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lat_q;
    logic [CW-1:0] dl_q;
    logic          busy_q;
    logic          resolve;
    logic          expire;

    // Decide the outcome of the current compare cycle.
    always_comb begin
        resolve = busy_q && (lat_q <= cnt_q);
        expire  = busy_q && (cnt_q >= dl_q);
        if (resolve)
            dec = DEC_RESOLVED;
        else if (expire)
            dec = DEC_FORCED;
        else
            dec = DEC_NONE;
    end

    assign busy = busy_q;

    // Track the compare in progress and its cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            lat_q  <= '0;
            dl_q   <= ONE;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= ONE;
            lat_q  <= lat_in;
            dl_q   <= (dl_in == '0) ? ONE : dl_in;
        end else if (dec != DEC_NONE) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q + ONE;
        end
    end

    // R7: a compare never runs past its deadline.
    p_deadline_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q <= dl_q));

    // R8: a forced outcome only occurs exactly at the deadline.
    p_forced_at_deadline_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec == DEC_FORCED) |-> (cnt_q == dl_q));

    // R7: the enclosing unit never starts a compare over a running one.
    p_start_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q);

endmodule

// File: rtl/wp_max_track.sv
// Running-maximum tracker and result register.
// A first sample loads the maximum directly. Other samples are held as a
// pending operand until the timer reports an outcome. A forced outcome keeps
// the current maximum and sets the window's sticky timeout flag.
module wp_max_track
    import win_pool_pkg::*;
#(
    parameter int MW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_first,
    input  logic          cap_opnd,
    input  logic          last_in,
    input  logic [MW-1:0] mag_in,
    input  dec_e          dec,
    output logic          out_valid,
    output logic [MW-1:0] out_max,
    output logic          out_timeout
);

    logic [MW-1:0] max_q;
    logic [MW-1:0] opnd_q;
    logic          to_q;
    logic          last_q;
    logic          out_valid_q;
    logic [MW-1:0] out_max_q;
    logic          out_to_q;
    logic [MW-1:0] pick;
    logic          to_next;

    // Select the survivor of the current decision.
    always_comb begin
        if (dec == DEC_RESOLVED && opnd_q > max_q)
            pick = opnd_q;
        else
            pick = max_q;
        to_next = to_q || (dec == DEC_FORCED);
    end

    // Update the maximum, the pending operand and the result pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_q       <= '0;
            opnd_q      <= '0;
            to_q        <= 1'b0;
            last_q      <= 1'b0;
            out_valid_q <= 1'b0;
            out_max_q   <= '0;
            out_to_q    <= 1'b0;
        end else begin
            out_valid_q <= 1'b0;
            if (load_first) begin
                max_q <= mag_in;
                to_q  <= 1'b0;
                if (last_in) begin
                    out_valid_q <= 1'b1;
                    out_max_q   <= mag_in;
                    out_to_q    <= 1'b0;
                end
            end else if (cap_opnd) begin
                opnd_q <= mag_in;
                last_q <= last_in;
            end
            if (dec != DEC_NONE) begin
                max_q <= pick;
                to_q  <= to_next;
                if (last_q) begin
                    out_valid_q <= 1'b1;
                    out_max_q   <= pick;
                    out_to_q    <= to_next;
                end
            end
        end
    end

    assign out_valid   = out_valid_q;
    assign out_max     = out_max_q;
    assign out_timeout = out_to_q;

    // R5: a resolved compare leaves a maximum no smaller than the operand.
    p_keep_larger_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec == DEC_RESOLVED) |=> (max_q >= $past(opnd_q)));

    // R8: a forced decision leaves the maximum untouched.
    p_forced_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec == DEC_FORCED) |=> $stable(max_q));

    // R11: without an accepted first sample or a decision the maximum holds.
    p_idle_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_first && dec == DEC_NONE) |=> $stable(max_q));

    // R9: a forced decision raises the window's timeout flag.
    p_sticky_timeout_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec == DEC_FORCED) |=> to_q);

    // R6: the presented result matches the tracked maximum.
    p_result_matches_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_q |-> (out_max_q == max_q));

endmodule

// File: rtl/win_absmax_pool.sv
// Serial absolute-maximum pooling unit, top level.
// Accepts one signed sample per handshake and turns it into a saturated
// magnitude. The magnitude is either loaded (first of window) or compared
// against the running maximum through a comparator whose latency is bounded
// by a deadline. in_ready drops while a compare is outstanding.
module win_absmax_pool
    import win_pool_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int CNT_W  = DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic              in_last,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CNT_W-1:0]  in_lat,
    input  logic [CNT_W-1:0]  in_deadline,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-2:0] out_max,
    output logic              out_timeout
);

    localparam int MW = DATA_W - 1;

    logic          busy;
    logic          accept;
    logic          load_first;
    logic          cap_opnd;
    logic [MW-1:0] mag;
    dec_e          dec;

    // Handshake and routing of an accepted sample.
    always_comb begin
        in_ready   = !busy;
        accept     = in_valid && !busy;
        load_first = accept && in_first;
        cap_opnd   = accept && !in_first;
    end

    wp_abs_sat #(.W(DATA_W)) u_abs (
        .din (in_data),
        .mag (mag)
    );

    wp_cmp_timer #(.CW(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (cap_opnd),
        .lat_in (in_lat),
        .dl_in  (in_deadline),
        .busy   (busy),
        .dec    (dec)
    );

    wp_max_track #(.MW(MW)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_first  (load_first),
        .cap_opnd    (cap_opnd),
        .last_in     (in_last),
        .mag_in      (mag),
        .dec         (dec),
        .out_valid   (out_valid),
        .out_max     (out_max),
        .out_timeout (out_timeout)
    );

    // R4: a first sample never starts a compare.
    p_first_no_compare_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_first) |=> in_ready);

    // R7: accepting a non-first sample always opens a compare.
    p_compare_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !in_first) |=> !in_ready);

endmodule

// File: tb/sim_win_absmax_pool.sv
// Self-checking bench for win_absmax_pool: a table of windows, then directed tests.
module sim_win_absmax_pool;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_first = 1'b0;
    logic       in_last = 1'b0;
    logic [7:0] in_data = '0;
    logic [3:0] in_lat = '0;
    logic [3:0] in_deadline = 4'd1;
    logic       in_ready;
    logic       out_valid;
    logic [6:0] out_max;
    logic       out_timeout;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    win_absmax_pool u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_last(in_last), .in_data(in_data), .in_lat(in_lat),
        .in_deadline(in_deadline), .in_ready(in_ready), .out_valid(out_valid),
        .out_max(out_max), .out_timeout(out_timeout)
    );

    // Window table: samples packed bytewise (sample 0 in bits 7:0).
    // Row 2 holds 0x80 (R3), row 3 forces every compare (R8, R9),
    // row 6 has latency equal to deadline, row 7 uses deadline 0 (R10),
    // row 8 is a clean window after a timed-out one (R9).
    localparam int NW = 9;
    localparam logic [31:0] W_SAMP [NW] = '{32'h0007EC05, 32'h329B64FD, 32'h00000080,
        32'h00FB5A0A, 32'h0000FF01, 32'h000000B3, 32'hC33B3CC4, 32'h00008100, 32'h00000904};
    localparam int W_N   [NW] = '{3, 4, 2, 3, 2, 1, 4, 2, 2};
    localparam int W_LAT [NW] = '{2, 1, 2, 6, 0, 4, 15, 3, 1};
    localparam int W_DL  [NW] = '{8, 3, 4, 3, 1, 4, 15, 0, 2};
    localparam int W_EXP [NW] = '{20, 101, 127, 10, 1, 77, 61, 0, 9};
    localparam int W_TO  [NW] = '{0, 0, 0, 1, 0, 0, 0, 1, 0};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Offer one sample, wait for acceptance, then count cycles with in_ready low.
    task automatic send(input logic [7:0] d, input bit f, input bit l,
                        input int lat, input int dl, output int stall);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_first = f; in_last = l; in_data = d;
        in_lat = 4'(lat); in_deadline = 4'(dl);
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
        stall = 0;
        while (!in_ready) begin
            stall++;
            @(negedge clk);
        end
    endtask

    function automatic int exp_stall(input int lat, input int dl);
        int d = (dl == 0) ? 1 : dl;
        int l = (lat == 0) ? 1 : lat;
        return (l < d) ? l : d;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    initial begin
        int st;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(out_max == 7'd0, "R1 out_max", out_max, 0);
        chk(out_timeout == 1'b0, "R1 out_timeout", out_timeout, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2, R3, R5, R6, R7, R8, R9, R10
        for (int w = 0; w < NW; w++) begin
            for (int k = 0; k < W_N[w]; k++) begin
                send(W_SAMP[w][8*k +: 8], k == 0, k == W_N[w] - 1, W_LAT[w], W_DL[w], st);
                if (k == 0)
                    chk(st == 0, "R4 first sample stall", st, 0);
                else
                    chk(st == exp_stall(W_LAT[w], W_DL[w]), "R7 compare cycles",
                        st, exp_stall(W_LAT[w], W_DL[w]));
            end
            chk(out_valid == 1'b1, "R6 result valid", out_valid, 1);
            chk(out_max == 7'(W_EXP[w]), "R5 window maximum", out_max, W_EXP[w]);
            chk(out_timeout == 1'(W_TO[w]), "R9 timeout flag", out_timeout, W_TO[w]);
            @(negedge clk);
            chk(out_valid == 1'b0, "R6 single pulse", out_valid, 0);
        end

        // R3: most negative code alone saturates to 127
        send(8'h80, 1'b1, 1'b1, 1, 1, st);
        chk(out_valid == 1'b1 && out_max == 7'd127, "R3 saturation", out_max, 127);

        // R11: idle-cycle inputs are ignored mid-window
        send(8'd3, 1'b1, 1'b0, 1, 4, st);
        in_data = 8'h80; in_first = 1'b1; in_last = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk(in_ready == 1'b1 && out_valid == 1'b0, "R11 no compare when idle", out_valid, 0);
        end
        in_first = 1'b0; in_last = 1'b0;
        send(8'd8, 1'b0, 1'b1, 2, 4, st);
        chk(out_max == 7'd8, "R11 junk ignored", out_max, 8);

        // R8: forced decision discards a larger operand; deadline bounds stall
        send(8'd20, 1'b1, 1'b0, 9, 4, st);
        send(8'hC0, 1'b0, 1'b1, 9, 4, st);
        chk(st == 4, "R8 deadline stall", st, 4);
        chk(out_max == 7'd20 && out_timeout == 1'b1, "R8 kept maximum", out_max, 20);

        // R10: deadline 0 acts as 1
        send(8'd2, 1'b1, 1'b0, 5, 0, st);
        send(8'd50, 1'b0, 1'b1, 5, 0, st);
        chk(st == 1, "R10 deadline zero", st, 1);
        chk(out_timeout == 1'b1, "R10 forced flag", out_timeout, 1);

        // R2: equal magnitudes of opposite sign
        send(8'hE2, 1'b1, 1'b0, 1, 2, st);
        send(8'd30, 1'b0, 1'b1, 1, 2, st);
        chk(out_max == 7'd30 && out_timeout == 1'b0, "R2 magnitude tie", out_max, 30);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule